// File: doc/BRIEF.md
# Cross-Clock Mailbox Pair

This block passes single control words between two ports that run on unrelated clocks, without using the data queue that sits beside it. Port A owns one 36-bit holding register, `box_ab`, that it writes and port B reads. Port B owns a second register, `box_ba`, that works the other way round. A port sees two kinds of transfer, mailbox or queue, and a per-port select input picks between them. The same select also chooses what the port's data output shows: either the mailbox word coming from the far side or the word from the queue's output register.

Each register has an active-low full flag. The flag sits in the reader's clock domain. A write on the owning port makes the flag go low once the event has crossed into the reader's clock. A read by the reader makes it go high again at once. The writer's side does not look at the flag itself. It tracks its own copy of the handshake state and refuses new writes until it has seen the read acknowledged. This means a word is never overwritten before it has been consumed. Reads do not change the stored word.

Top module: `xdom_mailbox`

## Requirements
- R1: A mailbox write loads the data input into the port's own register on that port's rising clock edge, provided the register is free. Port A loads `box_ab` from `din_a` and port B loads `box_ba` from `din_b`. A mailbox write is `cs_x_n`=0, `wdir_x`=1, `en_x`=1 and `box_sel_x`=1.
- R2: After an accepted write, the reader-domain flag (`ab_full_n` in the clk_b domain, `ba_full_n` in the clk_a domain) goes low after the second rising edge of the reader clock that follows the write.
- R3: Mailbox writes are ignored, and leave the register unchanged, in two cases. The first is while the last word is still unread. The second is until two writer-clock rising edges have passed after the read that consumed it. The third writer edge after the read accepts a new word.
- R4: A mailbox read is `cs_x_n`=0, `wdir_x`=0, `en_x`=1 and `box_sel_x`=1. When the reader's flag is low, a mailbox read sets the flag high right after that reader clock edge. A mailbox read while the flag is already high changes nothing.
- R5: `dout_b` shows `box_ab` when `box_sel_b`=1 and shows `fifo_q_b` when it is 0. In the same way, `dout_a` shows `box_ba` or `fifo_q_a`.
- R6: A mailbox read leaves the stored word in place. Repeated reads return the same value until a new write is accepted.
- R7: A write with `box_sel_x`=0, with `cs_x_n`=1 or with `en_x`=0 has no effect on either mailbox register or either flag.
- R8: While `rst_a_n`/`rst_b_n` is low at its clock edge, both flags go high, both registers clear to zero and both writers become free. Each reset is synchronous to its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A synchronous reset, active low |
| cs_a_n | input | 1 | Port A select, active low |
| wdir_a | input | 1 | Port A direction, 1 = write, 0 = read |
| en_a | input | 1 | Port A transfer enable |
| box_sel_a | input | 1 | Port A mailbox select (1) or queue select (0) |
| din_a | input | 36 | Port A write data |
| fifo_q_a | input | 36 | Queue output word for port A |
| dout_a | output | 36 | Port A read data |
| ba_full_n | output | 1 | Flag for `box_ba` in the clk_a domain, low = unread word |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B synchronous reset, active low |
| cs_b_n | input | 1 | Port B select, active low |
| wdir_b | input | 1 | Port B direction, 1 = write, 0 = read |
| en_b | input | 1 | Port B transfer enable |
| box_sel_b | input | 1 | Port B mailbox select (1) or queue select (0) |
| din_b | input | 36 | Port B write data |
| fifo_q_b | input | 36 | Queue output word for port B |
| dout_b | output | 36 | Port B read data |
| ab_full_n | output | 1 | Flag for `box_ab` in the clk_b domain, low = unread word |

## Verification
A handshake bit that is stuck or toggles twice shows at the reader as a flag that never drops, or that drops twice, within the two reader edges that follow a write. A lost acknowledge leaves the writer blocked for good. The next word then never reaches the far port, and the reader's flag stays high. A missing block on the writer side shows as the reader's output word changing between two reads, or before any read. The reference model checks this on the next edge of the reader clock after the writer edge at which it happens.

// File: rtl/xmb_pkg.sv
// Shared types for the cross-clock mailbox pair.
package xmb_pkg;

    // Decoded per-port mailbox request for one clock cycle.
    typedef struct packed {
        logic box_wr;
        logic box_rd;
    } xmb_cmd_t;

    // Turns the raw port controls into mailbox write/read strobes.
    function automatic xmb_cmd_t xmb_decode(input logic cs_n, input logic wdir,
                                            input logic en, input logic sel);
        xmb_cmd_t c;
        logic     hit;
        hit      = ~cs_n & en & sel;
        c.box_wr = hit & wdir;
        c.box_rd = hit & ~wdir;
        return c;
    endfunction

endpackage

// File: rtl/xmb_port.sv
// Port front end: decodes the transfer controls and steers the data output.
// Assumes: the inputs come from the port's own clock domain; the mailbox
// word from the far side is held still while it is unread.
module xmb_port #(
    parameter int W = 36
) (
    input  logic              cs_n,
    input  logic              wdir,
    input  logic              en,
    input  logic              box_sel,
    input  logic [W-1:0]      fifo_q,
    input  logic [W-1:0]      box_rx,
    output xmb_pkg::xmb_cmd_t cmd,
    output logic [W-1:0]      dout
);

    // Mailbox strobes for this cycle.
    always_comb cmd = xmb_pkg::xmb_decode(cs_n, wdir, en, box_sel);

    // Output data: mailbox word when selected, otherwise the queue word.
    always_comb dout = box_sel ? box_rx : fifo_q;

endmodule

// File: rtl/xmb_sync.sv
// Multi-flop synchronizer for a single level signal.
// Assumes: STAGES >= 2; the input changes no faster than once per
// STAGES destination cycles (the toggle handshake guarantees this).
module xmb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the level through the chain; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/xmb_chan.sv
// One mailbox direction: holding register plus toggle handshake.
// The writer flips wr_tog on each accepted write and refuses writes while
// its synced copy of rd_tog differs. The reader sees an unread word while
// its synced copy of wr_tog differs from rd_tog, and flips rd_tog on a read.
// Assumes: both resets are asserted together at power-up.
module xmb_chan #(
    parameter int W      = 36,
    parameter int STAGES = 2
) (
    input  logic         wclk,
    input  logic         wrst_n,
    input  logic         wr_req,
    input  logic [W-1:0] wdata,
    input  logic         rclk,
    input  logic         rrst_n,
    input  logic         rd_req,
    output logic [W-1:0] box_q,
    output logic         busy,
    output logic         full_n
);

    logic wr_tog, rd_tog, ack_seen, req_seen, unread, accept;

    // Writer side: blocked from a write until the read of it is echoed back.
    assign busy   = wr_tog ^ ack_seen;
    assign accept = wr_req & ~busy;

    // Capture the word and announce it with a toggle.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            wr_tog <= 1'b0;
            box_q  <= '0;
        end else if (accept) begin
            wr_tog <= ~wr_tog;
            box_q  <= wdata;
        end
    end

    xmb_sync #(.STAGES(STAGES)) u_req_sync (
        .clk  (rclk),
        .rst_n(rrst_n),
        .d    (wr_tog),
        .q    (req_seen)
    );

    // Reader side: a word is pending while the two toggles disagree.
    assign unread = req_seen ^ rd_tog;
    assign full_n = ~unread;

    // Acknowledge a read of a pending word by matching the toggle.
    always_ff @(posedge rclk) begin
        if (!rrst_n)              rd_tog <= 1'b0;
        else if (rd_req & unread) rd_tog <= ~rd_tog;
    end

    xmb_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk  (wclk),
        .rst_n(wrst_n),
        .d    (rd_tog),
        .q    (ack_seen)
    );

endmodule

// File: rtl/xdom_mailbox.sv
// Cross-clock mailbox pair between port A (clk_a) and port B (clk_b).
// Port p writes mailbox p; the other port reads it. Box 0 = box_ab,
// box 1 = box_ba. Each flag lives in its reader's clock domain.
// Assumes: resets are synchronous to their own clocks and overlap at start.
module xdom_mailbox #(
    parameter int DATA_W      = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_a,
    input  logic              rst_a_n,
    input  logic              cs_a_n,
    input  logic              wdir_a,
    input  logic              en_a,
    input  logic              box_sel_a,
    input  logic [DATA_W-1:0] din_a,
    input  logic [DATA_W-1:0] fifo_q_a,
    output logic [DATA_W-1:0] dout_a,
    output logic              ba_full_n,
    input  logic              clk_b,
    input  logic              rst_b_n,
    input  logic              cs_b_n,
    input  logic              wdir_b,
    input  logic              en_b,
    input  logic              box_sel_b,
    input  logic [DATA_W-1:0] din_b,
    input  logic [DATA_W-1:0] fifo_q_b,
    output logic [DATA_W-1:0] dout_b,
    output logic              ab_full_n
);

    localparam int NPORT = 2;

    logic [NPORT-1:0]  clk_v, rst_v, cs_v, wdir_v, en_v, sel_v;
    logic [NPORT-1:0]  wr_cmd, rd_cmd, busy_w, flag_n;
    logic [DATA_W-1:0] din_v  [NPORT];
    logic [DATA_W-1:0] fifo_v [NPORT];
    logic [DATA_W-1:0] dout_v [NPORT];
    logic [DATA_W-1:0] box_q  [NPORT];
    xmb_pkg::xmb_cmd_t cmd_v  [NPORT];

    // Gather the scalar ports into per-port vectors (index 0 = A, 1 = B).
    assign clk_v  = {clk_b, clk_a};
    assign rst_v  = {rst_b_n, rst_a_n};
    assign cs_v   = {cs_b_n, cs_a_n};
    assign wdir_v = {wdir_b, wdir_a};
    assign en_v   = {en_b, en_a};
    assign sel_v  = {box_sel_b, box_sel_a};
    assign din_v[0]  = din_a;
    assign din_v[1]  = din_b;
    assign fifo_v[0] = fifo_q_a;
    assign fifo_v[1] = fifo_q_b;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        xmb_port #(.W(DATA_W)) u_port (
            .cs_n   (cs_v[p]),
            .wdir   (wdir_v[p]),
            .en     (en_v[p]),
            .box_sel(sel_v[p]),
            .fifo_q (fifo_v[p]),
            .box_rx (box_q[NPORT-1-p]),
            .cmd    (cmd_v[p]),
            .dout   (dout_v[p])
        );

        assign wr_cmd[p] = cmd_v[p].box_wr;
        assign rd_cmd[p] = cmd_v[p].box_rd;

        xmb_chan #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_chan (
            .wclk  (clk_v[p]),
            .wrst_n(rst_v[p]),
            .wr_req(wr_cmd[p]),
            .wdata (din_v[p]),
            .rclk  (clk_v[NPORT-1-p]),
            .rrst_n(rst_v[NPORT-1-p]),
            .rd_req(rd_cmd[NPORT-1-p]),
            .box_q (box_q[p]),
            .busy  (busy_w[p]),
            .full_n(flag_n[p])
        );
    end

    assign dout_a    = dout_v[0];
    assign dout_b    = dout_v[1];
    assign ab_full_n = flag_n[0];
    assign ba_full_n = flag_n[1];

endmodule

// File: rtl/xdom_mailbox_chk.sv
// Assertion checker for xdom_mailbox, attached by bind below.
// Assumes: the two clocks have no coincident rising edges, so a signal
// from one domain can be sampled safely at the other domain's edge.
module xdom_mailbox_chk #(
    parameter int W = 36
) (
    input logic         clk_a,
    input logic         clk_b,
    input logic         rst_a_n,
    input logic         rst_b_n,
    input logic [1:0]   wr_cmd,
    input logic [1:0]   rd_cmd,
    input logic [1:0]   busy,
    input logic [W-1:0] box_ab,
    input logic [W-1:0] box_ba,
    input logic [W-1:0] din_a,
    input logic [W-1:0] din_b,
    input logic         ab_full_n,
    input logic         ba_full_n
);

    logic in_rst;
    assign in_rst = !rst_a_n || !rst_b_n;

    assert_load_ab_R1: assert property (@(posedge clk_a) disable iff (in_rst)
        (wr_cmd[0] && !busy[0]) |=> box_ab == $past(din_a));
    assert_load_ba_R1: assert property (@(posedge clk_b) disable iff (in_rst)
        (wr_cmd[1] && !busy[1]) |=> box_ba == $past(din_b));

    assert_hold_ab_R3: assert property (@(posedge clk_a) disable iff (in_rst)
        busy[0] |=> $stable(box_ab));
    assert_hold_ba_R3: assert property (@(posedge clk_b) disable iff (in_rst)
        busy[1] |=> $stable(box_ba));

    // R3: an unread word at the reader always means a blocked writer.
    assert_unread_blocks_ab_R3: assert property (@(posedge clk_b) disable iff (in_rst)
        !ab_full_n |-> busy[0]);
    assert_unread_blocks_ba_R3: assert property (@(posedge clk_a) disable iff (in_rst)
        !ba_full_n |-> busy[1]);

    assert_read_sets_ab_R4: assert property (@(posedge clk_b) disable iff (in_rst)
        (rd_cmd[1] && !ab_full_n) |=> ab_full_n);
    assert_read_sets_ba_R4: assert property (@(posedge clk_a) disable iff (in_rst)
        (rd_cmd[0] && !ba_full_n) |=> ba_full_n);

    assert_read_keeps_ab_R6: assert property (@(posedge clk_b) disable iff (in_rst)
        (rd_cmd[1] && !ab_full_n) |=> $stable(box_ab));
    assert_read_keeps_ba_R6: assert property (@(posedge clk_a) disable iff (in_rst)
        (rd_cmd[0] && !ba_full_n) |=> $stable(box_ba));

endmodule

bind xdom_mailbox xdom_mailbox_chk #(.W(DATA_W)) u_chk (
    .clk_a    (clk_a),
    .clk_b    (clk_b),
    .rst_a_n  (rst_a_n),
    .rst_b_n  (rst_b_n),
    .wr_cmd   (wr_cmd),
    .rd_cmd   (rd_cmd),
    .busy     (busy_w),
    .box_ab   (box_q[0]),
    .box_ba   (box_q[1]),
    .din_a    (din_a),
    .din_b    (din_b),
    .ab_full_n(ab_full_n),
    .ba_full_n(ba_full_n)
);

// File: tb/sim_xdom_mailbox.sv
`timescale 1ns/100ps
// Bench for xdom_mailbox: directed checks plus a behavioural reference
// model compared on every clock of both domains.
module sim_xdom_mailbox;

    localparam logic [35:0] FQ_A = 36'hA_1111_0000;
    localparam logic [35:0] FQ_B = 36'hB_2222_0000;

    logic        clk_a = 1'b0, clk_b = 1'b0;
    logic        rst_a_n = 1'b0, rst_b_n = 1'b0;
    logic        cs_a_n = 1'b1, wdir_a = 1'b0, en_a = 1'b0, box_sel_a = 1'b1;
    logic        cs_b_n = 1'b1, wdir_b = 1'b0, en_b = 1'b0, box_sel_b = 1'b1;
    logic [35:0] din_a = '0, din_b = '0, fifo_q_a = FQ_A, fifo_q_b = FQ_B;
    logic [35:0] dout_a, dout_b;
    logic        ab_full_n, ba_full_n;

    int n_chk = 0, n_fail = 0;
    bit cmp_on = 0;

    // 200 MHz on port A; port B at 7 ns with an offset so edges never meet.
    always #2.5 clk_a = ~clk_a;
    initial begin
        #1.3 clk_b = 1'b1;
        forever #3.5 clk_b = ~clk_b;
    end

    xdom_mailbox u0 (
        .clk_a(clk_a), .rst_a_n(rst_a_n), .cs_a_n(cs_a_n), .wdir_a(wdir_a),
        .en_a(en_a), .box_sel_a(box_sel_a), .din_a(din_a), .fifo_q_a(fifo_q_a),
        .dout_a(dout_a), .ba_full_n(ba_full_n),
        .clk_b(clk_b), .rst_b_n(rst_b_n), .cs_b_n(cs_b_n), .wdir_b(wdir_b),
        .en_b(en_b), .box_sel_b(box_sel_b), .din_b(din_b), .fifo_q_b(fifo_q_b),
        .dout_b(dout_b), .ab_full_n(ab_full_n)
    );

    task automatic chk_w(input string tag, input logic [35:0] got, input logic [35:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic chk_b(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [35:0] m_ab = '0, m_ba = '0;
    bit wbusy_ab = 0, wbusy_ba = 0, full_ab = 0, full_ba = 0;
    int wseq_ab = 0, rseq_ab = 0, wseq_ba = 0, rseq_ba = 0;
    int seen_ack_ab = 0, seen_ack_ba = 0, seen_wr_ab = 0, seen_wr_ba = 0;
    int ack_ab = 0, ack_ba = 0, pend_ab = 0, pend_ba = 0;
    logic cmd_wa, cmd_ra, cmd_wb, cmd_rb;
    assign cmd_wa = !cs_a_n && en_a && box_sel_a && wdir_a;
    assign cmd_ra = !cs_a_n && en_a && box_sel_a && !wdir_a;
    assign cmd_wb = !cs_b_n && en_b && box_sel_b && wdir_b;
    assign cmd_rb = !cs_b_n && en_b && box_sel_b && !wdir_b;

    // Port A edge: writer of box_ab, reader of box_ba.
    always @(posedge clk_a) begin
        if (!rst_a_n) begin
            m_ab = '0; wbusy_ab = 0; ack_ab = 0; seen_ack_ab = rseq_ab;
            full_ba = 0; pend_ba = 0; seen_wr_ba = wseq_ba;
        end else begin
            if (cmd_wa && !wbusy_ab) begin m_ab = din_a; wbusy_ab = 1; wseq_ab++; end
            if (rseq_ab != seen_ack_ab) begin seen_ack_ab = rseq_ab; ack_ab = 1; end
            else if (ack_ab == 1) begin ack_ab = 0; wbusy_ab = 0; end
            if (cmd_ra && full_ba) begin full_ba = 0; rseq_ba++; end
            if (wseq_ba != seen_wr_ba) begin seen_wr_ba = wseq_ba; pend_ba = 1; end
            else if (pend_ba == 1) begin pend_ba = 0; full_ba = 1; end
        end
    end

    // Port B edge: writer of box_ba, reader of box_ab.
    always @(posedge clk_b) begin
        if (!rst_b_n) begin
            m_ba = '0; wbusy_ba = 0; ack_ba = 0; seen_ack_ba = rseq_ba;
            full_ab = 0; pend_ab = 0; seen_wr_ab = wseq_ab;
        end else begin
            if (cmd_wb && !wbusy_ba) begin m_ba = din_b; wbusy_ba = 1; wseq_ba++; end
            if (rseq_ba != seen_ack_ba) begin seen_ack_ba = rseq_ba; ack_ba = 1; end
            else if (ack_ba == 1) begin ack_ba = 0; wbusy_ba = 0; end
            if (cmd_rb && full_ab) begin full_ab = 0; rseq_ab++; end
            if (wseq_ab != seen_wr_ab) begin seen_wr_ab = wseq_ab; pend_ab = 1; end
            else if (pend_ab == 1) begin pend_ab = 0; full_ab = 1; end
        end
    end

    // Per-clock comparison away from the active edges.
    always @(negedge clk_a) if (cmp_on) begin
        chk_b("R2/R4 model ba_full_n", ba_full_n, !full_ba);
        chk_w("R5/R6 model dout_a", dout_a, box_sel_a ? m_ba : fifo_q_a);
    end
    always @(negedge clk_b) if (cmp_on) begin
        chk_b("R2/R4 model ab_full_n", ab_full_n, !full_ab);
        chk_w("R5/R6 model dout_b", dout_b, box_sel_b ? m_ab : fifo_q_b);
    end

    // ---------------- drivers ----------------
    task automatic a_drv(input logic cs_n, input logic wd, input logic en,
                         input logic sel, input logic [35:0] d);
        @(posedge clk_a); #1;
        cs_a_n = cs_n; wdir_a = wd; en_a = en; box_sel_a = sel; din_a = d;
    endtask

    task automatic b_drv(input logic cs_n, input logic wd, input logic en,
                         input logic sel, input logic [35:0] d);
        @(posedge clk_b); #1;
        cs_b_n = cs_n; wdir_b = wd; en_b = en; box_sel_b = sel; din_b = d;
    endtask

    task automatic wait_a(input int n);
        repeat (n) @(posedge clk_a);
        @(negedge clk_a);
    endtask

    task automatic wait_b(input int n);
        repeat (n) @(posedge clk_b);
        @(negedge clk_b);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk_a);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        fork
            begin repeat (4) @(posedge clk_a); #1 rst_a_n = 1'b1; end
            begin repeat (4) @(posedge clk_b); #1 rst_b_n = 1'b1; end
        join
        cmp_on = 1;

        // R8: reset state.
        @(negedge clk_b);
        chk_b("R8 ab_full_n after reset", ab_full_n, 1'b1);
        chk_w("R8 box_ab cleared", dout_b, 36'h0);
        @(negedge clk_a);
        chk_b("R8 ba_full_n after reset", ba_full_n, 1'b1);
        chk_w("R8 box_ba cleared", dout_a, 36'h0);

        // R1, R2: first word from A to B.
        a_drv(0, 1, 1, 1, 36'h1_2345_6789);
        a_drv(1, 0, 0, 1, '0);
        wait_b(3);
        chk_b("R2 ab_full_n low after write", ab_full_n, 1'b0);
        chk_w("R1 box_ab loaded", dout_b, 36'h1_2345_6789);

        // R3: a second write while unread is dropped.
        a_drv(0, 1, 1, 1, 36'hF_0000_000F);
        a_drv(1, 0, 0, 1, '0);
        wait_b(2);
        chk_w("R3 write ignored while unread", dout_b, 36'h1_2345_6789);

        // R4, R6: read clears flag, word stays.
        b_drv(0, 0, 1, 1, '0);
        b_drv(1, 0, 0, 1, '0);
        @(negedge clk_b);
        chk_b("R4 ab_full_n high after read", ab_full_n, 1'b1);
        chk_w("R6 word kept after read", dout_b, 36'h1_2345_6789);
        wait_a(6);
        b_drv(0, 0, 1, 1, '0);
        b_drv(1, 0, 0, 1, '0);
        @(negedge clk_b);
        chk_b("R4 read while empty no effect", ab_full_n, 1'b1);
        chk_w("R6 second read same word", dout_b, 36'h1_2345_6789);

        // R7: non-mailbox or inactive writes do nothing.
        a_drv(0, 1, 1, 0, 36'h7_7777_7777);
        a_drv(1, 1, 1, 1, 36'h7_7777_7777);
        a_drv(0, 1, 0, 1, 36'h7_7777_7777);
        a_drv(1, 0, 0, 1, '0);
        wait_b(4);
        chk_b("R7 flag unchanged", ab_full_n, 1'b1);
        chk_w("R7 box_ab unchanged", dout_b, 36'h1_2345_6789);

        // R1: a new word after acknowledge.
        a_drv(0, 1, 1, 1, 36'h3_CAFE_0003);
        a_drv(1, 0, 0, 1, '0);
        wait_b(3);
        chk_b("R2 flag low for new word", ab_full_n, 1'b0);
        chk_w("R1 new word loaded", dout_b, 36'h3_CAFE_0003);
        b_drv(0, 0, 1, 1, '0);
        b_drv(1, 0, 0, 1, '0);
        wait_a(4);

        // R5: queue path on both ports.
        b_drv(1, 0, 0, 0, '0);
        @(negedge clk_b);
        chk_w("R5 dout_b from queue", dout_b, FQ_B);
        b_drv(1, 0, 0, 1, '0);
        @(negedge clk_b);
        chk_w("R5 dout_b back to box", dout_b, 36'h3_CAFE_0003);
        a_drv(1, 0, 0, 0, '0);
        @(negedge clk_a);
        chk_w("R5 dout_a from queue", dout_a, FQ_A);
        a_drv(1, 0, 0, 1, '0);

        // R1, R2, R3, R4: the B-to-A direction.
        b_drv(0, 1, 1, 1, 36'h5_0A0A_0505);
        b_drv(0, 1, 1, 1, 36'h6_DEAD_0006);
        b_drv(1, 0, 0, 1, '0);
        wait_a(3);
        chk_b("R2 ba_full_n low after write", ba_full_n, 1'b0);
        chk_w("R1 box_ba loaded", dout_a, 36'h5_0A0A_0505);
        chk_w("R3 back-to-back write dropped", dout_a, 36'h5_0A0A_0505);
        a_drv(0, 0, 1, 1, '0);
        a_drv(1, 0, 0, 1, '0);
        @(negedge clk_a);
        chk_b("R4 ba_full_n high after read", ba_full_n, 1'b1);

        // Mixed traffic on both ports; the model checks every clock.
        fork
            for (int i = 0; i < 600; i++)
                a_drv(1'($urandom % 4 == 0), 1'($urandom % 2), 1'($urandom % 4 != 0),
                      1'($urandom % 3 != 0), {4'($urandom), 32'($urandom)});
            for (int j = 0; j < 430; j++)
                b_drv(1'($urandom % 4 == 0), 1'($urandom % 2), 1'($urandom % 4 != 0),
                      1'($urandom % 3 != 0), {4'($urandom), 32'($urandom)});
        join
        fork
            a_drv(1, 0, 0, 1, '0);
            b_drv(1, 0, 0, 1, '0);
        join
        wait_a(10);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule